// File: doc/BRIEF.md
# Inbound Abort Completion Generator

This block sits behind the inbound decode stage of a bus bridge. It takes request descriptors that decode has already marked as failed and produces whatever the protocol owes the requester. An aborted read gets a completion whose status shows whether a master abort (unsupported request) or a target abort occurred. That completion carries one all-ones data phase for every phase the read asked for. An aborted write is discarded and only logged. An unsupported special-cycle message is also logged. It gets a header-only completion only when its completion-required flag is set.

Both streams use valid/ready handshakes. A request transfers on a cycle where `req_valid` and `req_ready` are both high. The block raises `req_ready` only while no completion is pending, so it accepts one request at a time. A completion is a header beat (`cpl_sop` high) followed by its data beats, one per cycle, with `cpl_last` marking the final beat. While `cpl_valid` is high and `cpl_ready` is low, every completion output holds its value, and the beat stays until it is taken. An upstream error collector receives a one-cycle pulse with a class code for each accepted request.

Top module: `abort_cpl_gen`

## Requirements
- R1: An accepted read (`req_kind`=0) with `req_abort`=0 yields a completion whose `cpl_status` is 1 (unsupported request), and the error code logged for it is 0.
- R2: An accepted read with `req_abort`=1 yields a completion whose `cpl_status` is 2 (target abort), and the error code logged for it is 1.
- R3: A read completion has a header beat carrying `cpl_data`=0, followed by exactly `req_len` data beats. Each data beat carries all-ones `cpl_data`, and `cpl_last` is high only on the final beat.
- R4: A read with `req_len`=0 yields a single header beat with `cpl_last` high and `cpl_len`=0.
- R5: An accepted write (`req_kind`=1) yields no completion, regardless of `req_abort`. It logs error code 2, and `req_ready` stays high.
- R6: A special cycle (`req_kind` 2 or 3) logs error code 3. If `req_cpl_req`=1, it yields one header beat with `cpl_status`=3, `cpl_last` high and `cpl_len`=0; otherwise it yields nothing.
- R7: On every beat of a completion, `cpl_tag` and `cpl_rid` echo the request's tag and requester id. On every beat of a read completion, `cpl_len` equals `req_len`.
- R8: While `cpl_valid` is high and `cpl_ready` is low, all completion outputs hold their values into the next cycle.
- R9: `req_ready` is low from the cycle after a completion-producing request is accepted until the final beat of that completion is taken. `cpl_valid` is high exactly in that span.
- R10: `err_valid` is high for exactly the one cycle after each accepted request, together with that request's code.
- R11: Out of reset, `cpl_valid` and `err_valid` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request descriptor valid |
| req_ready | output | 1 | Block can accept a request |
| req_kind | input | 2 | 0 read, 1 write, 2 or 3 special cycle |
| req_abort | input | 1 | 0 master abort, 1 target abort |
| req_cpl_req | input | 1 | Completion-required flag for special cycles |
| req_len | input | LEN_W | Requested data phases |
| req_tag | input | TAG_W | Request tag |
| req_rid | input | RID_W | Requester identifier |
| cpl_valid | output | 1 | Completion beat valid |
| cpl_ready | input | 1 | Downstream takes the beat |
| cpl_sop | output | 1 | Beat is the header |
| cpl_last | output | 1 | Final beat of the completion |
| cpl_status | output | 2 | 1 unsupported request, 2 target abort, 3 unsupported special cycle |
| cpl_tag | output | TAG_W | Echoed tag |
| cpl_rid | output | RID_W | Echoed requester id |
| cpl_len | output | LEN_W | Data phases that follow the header |
| cpl_data | output | DATA_W | Beat data |
| err_valid | output | 1 | Error log pulse |
| err_code | output | 2 | 0 read MA, 1 read TA, 2 write MA, 3 unsupported special cycle |

## Verification
The assertions assume that request fields stay constant while `req_valid` is high. They also assume that `cpl_ready` is an arbitrary but clean signal, with no unknown values after reset. The stimulus changes request fields and `cpl_ready` only just after a rising edge. It keeps a request asserted until the handshake completes, and it varies `cpl_ready` randomly so that stalls land on header beats, middle beats and last beats alike. Zero-length reads, the largest length, and special cycles with and without the flag appear among both the directed and the random requests.

// File: rtl/abort_cpl_pkg.sv
package abort_cpl_pkg;

  typedef enum logic [1:0] {
    KIND_READ  = 2'd0,
    KIND_WRITE = 2'd1,
    KIND_SPC   = 2'd2,
    KIND_SPC2  = 2'd3
  } req_kind_e;

  typedef enum logic [1:0] {
    CST_NONE   = 2'd0,
    CST_UNSUPP = 2'd1,
    CST_TARGET = 2'd2,
    CST_USC    = 2'd3
  } cpl_status_e;

  typedef enum logic [1:0] {
    ERR_RD_MA = 2'd0,
    ERR_RD_TA = 2'd1,
    ERR_WR_MA = 2'd2,
    ERR_USC   = 2'd3
  } err_class_e;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_HDR  = 2'd1,
    SEQ_DATA = 2'd2
  } seq_state_e;

endpackage

// File: rtl/abort_cpl_classify.sv
module abort_cpl_classify
  import abort_cpl_pkg::*;
#(
  parameter int LEN_W = 4
) (
  input  logic [1:0]       kind,
  input  logic             abort_tgt,
  input  logic             cpl_req,
  input  logic [LEN_W-1:0] len_in,
  output logic             needs_cpl,
  output logic [1:0]       status,
  output logic [1:0]       err_class,
  output logic [LEN_W-1:0] eff_len
);

  req_kind_e k;

  always_comb begin
    k         = req_kind_e'(kind);
    needs_cpl = 1'b0;
    status    = CST_NONE;
    err_class = ERR_USC;
    eff_len   = '0;
    unique case (k)
      KIND_READ: begin
        needs_cpl = 1'b1;
        eff_len   = len_in;
        if (abort_tgt) begin
          status    = CST_TARGET;
          err_class = ERR_RD_TA;
        end else begin
          status    = CST_UNSUPP;
          err_class = ERR_RD_MA;
        end
      end
      KIND_WRITE: begin
        err_class = ERR_WR_MA;
      end
      default: begin
        needs_cpl = cpl_req;
        status    = CST_USC;
        err_class = ERR_USC;
      end
    endcase
  end

endmodule

// File: rtl/abort_cpl_errlog.sv
module abort_cpl_errlog (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       accept,
  input  logic [1:0] code_in,
  output logic       err_valid,
  output logic [1:0] err_code
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      err_valid <= 1'b0;
      err_code  <= 2'd0;
    end else begin
      err_valid <= accept;
      if (accept) err_code <= code_in;
    end
  end

endmodule

// File: rtl/abort_cpl_beats.sv
module abort_cpl_beats
  import abort_cpl_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int TAG_W  = 8,
  parameter int RID_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [1:0]        ld_status,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic [TAG_W-1:0]  ld_tag,
  input  logic [RID_W-1:0]  ld_rid,
  output logic              idle,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic              cpl_sop,
  output logic              cpl_last,
  output logic [1:0]        cpl_status,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic [RID_W-1:0]  cpl_rid,
  output logic [LEN_W-1:0]  cpl_len,
  output logic [DATA_W-1:0] cpl_data
);

  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  seq_state_e       st;
  logic [LEN_W-1:0] left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st         <= SEQ_IDLE;
      left_q     <= '0;
      cpl_status <= 2'd0;
      cpl_tag    <= '0;
      cpl_rid    <= '0;
      cpl_len    <= '0;
    end else begin
      unique case (st)
        SEQ_IDLE: if (load) begin
          st         <= SEQ_HDR;
          cpl_status <= ld_status;
          cpl_tag    <= ld_tag;
          cpl_rid    <= ld_rid;
          cpl_len    <= ld_len;
        end
        SEQ_HDR: if (cpl_ready) begin
          if (cpl_len == '0) st <= SEQ_IDLE;
          else begin
            st     <= SEQ_DATA;
            left_q <= cpl_len;
          end
        end
        SEQ_DATA: if (cpl_ready) begin
          if (left_q == ONE) st <= SEQ_IDLE;
          left_q <= left_q - ONE;
        end
        default: st <= SEQ_IDLE;
      endcase
    end
  end

  always_comb begin
    idle      = (st == SEQ_IDLE);
    cpl_valid = (st != SEQ_IDLE);
    cpl_sop   = (st == SEQ_HDR);
    cpl_last  = ((st == SEQ_HDR) && (cpl_len == '0)) ||
                ((st == SEQ_DATA) && (left_q == ONE));
    cpl_data  = (st == SEQ_DATA) ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
  end

  a_r8_hold_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_sop) && $stable(cpl_last)
      && $stable(cpl_data) && $stable(cpl_tag) && $stable(cpl_rid) && $stable(cpl_status)));

  a_r3_data_follows_hdr: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_ready && cpl_sop && !cpl_last) |=> (cpl_valid && !cpl_sop));

  a_r9_done_goes_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && cpl_ready && cpl_last) |=> (!cpl_valid && idle));

endmodule

// File: rtl/abort_cpl_gen.sv
module abort_cpl_gen
  import abort_cpl_pkg::*;
#(
  parameter int LEN_W  = 4,
  parameter int TAG_W  = 8,
  parameter int RID_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic              req_abort,
  input  logic              req_cpl_req,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [RID_W-1:0]  req_rid,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic              cpl_sop,
  output logic              cpl_last,
  output logic [1:0]        cpl_status,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic [RID_W-1:0]  cpl_rid,
  output logic [LEN_W-1:0]  cpl_len,
  output logic [DATA_W-1:0] cpl_data,
  output logic              err_valid,
  output logic [1:0]        err_code
);

  logic             needs_cpl;
  logic [1:0]       cls_status;
  logic [1:0]       cls_err;
  logic [LEN_W-1:0] cls_len;
  logic             seq_idle;
  logic             accept;

  assign req_ready = seq_idle;
  assign accept    = req_valid && seq_idle;

  abort_cpl_classify #(.LEN_W(LEN_W)) u_cls (
    .kind      (req_kind),
    .abort_tgt (req_abort),
    .cpl_req   (req_cpl_req),
    .len_in    (req_len),
    .needs_cpl (needs_cpl),
    .status    (cls_status),
    .err_class (cls_err),
    .eff_len   (cls_len)
  );

  abort_cpl_beats #(
    .LEN_W(LEN_W), .TAG_W(TAG_W), .RID_W(RID_W), .DATA_W(DATA_W)
  ) u_beats (
    .clk        (clk),
    .rst_n      (rst_n),
    .load       (accept && needs_cpl),
    .ld_status  (cls_status),
    .ld_len     (cls_len),
    .ld_tag     (req_tag),
    .ld_rid     (req_rid),
    .idle       (seq_idle),
    .cpl_valid  (cpl_valid),
    .cpl_ready  (cpl_ready),
    .cpl_sop    (cpl_sop),
    .cpl_last   (cpl_last),
    .cpl_status (cpl_status),
    .cpl_tag    (cpl_tag),
    .cpl_rid    (cpl_rid),
    .cpl_len    (cpl_len),
    .cpl_data   (cpl_data)
  );

  abort_cpl_errlog u_err (
    .clk       (clk),
    .rst_n     (rst_n),
    .accept    (accept),
    .code_in   (cls_err),
    .err_valid (err_valid),
    .err_code  (err_code)
  );

  a_r1_read_ma: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 2'd0 && !req_abort) |=>
      (cpl_valid && cpl_sop && cpl_status == 2'd1 && err_valid && err_code == 2'd0));

  a_r2_read_ta: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 2'd0 && req_abort) |=>
      (cpl_valid && cpl_sop && cpl_status == 2'd2 && err_valid && err_code == 2'd1));

  a_r4_zero_len: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 2'd0 && req_len == '0) |=>
      (cpl_sop && cpl_last && cpl_len == '0));

  a_r5_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind == 2'd1) |=>
      (!cpl_valid && req_ready && err_valid && err_code == 2'd2));

  a_r6_spc_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && req_kind[1] && !req_cpl_req) |=>
      (!cpl_valid && err_valid && err_code == 2'd3));

endmodule

// File: tb/abort_cpl_gen_test.sv
`timescale 1ns/1ps
module abort_cpl_gen_test;

  localparam int LEN_W = 4, TAG_W = 8, RID_W = 16, DATA_W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [1:0] req_kind = 2'd0;
  logic req_abort = 1'b0, req_cpl_req = 1'b0;
  logic [LEN_W-1:0] req_len = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic [RID_W-1:0] req_rid = '0;
  logic cpl_valid, cpl_ready = 1'b1, cpl_sop, cpl_last;
  logic [1:0] cpl_status;
  logic [TAG_W-1:0] cpl_tag;
  logic [RID_W-1:0] cpl_rid;
  logic [LEN_W-1:0] cpl_len;
  logic [DATA_W-1:0] cpl_data;
  logic err_valid;
  logic [1:0] err_code;

  always #5 clk = ~clk;

  abort_cpl_gen #(.LEN_W(LEN_W), .TAG_W(TAG_W), .RID_W(RID_W), .DATA_W(DATA_W)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_kind(req_kind), .req_abort(req_abort), .req_cpl_req(req_cpl_req),
    .req_len(req_len), .req_tag(req_tag), .req_rid(req_rid),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_sop(cpl_sop),
    .cpl_last(cpl_last), .cpl_status(cpl_status), .cpl_tag(cpl_tag),
    .cpl_rid(cpl_rid), .cpl_len(cpl_len), .cpl_data(cpl_data),
    .err_valid(err_valid), .err_code(err_code));

  typedef struct {
    bit sop; bit last; logic [DATA_W-1:0] data; logic [1:0] status;
    logic [TAG_W-1:0] tag; logic [RID_W-1:0] rid; logic [LEN_W-1:0] len; string rq;
  } beat_t;

  beat_t exp_q[$];
  int checks = 0, errors = 0;
  bit err_pend = 0;
  logic [1:0] err_exp = 2'd0;
  bit stalled_prev = 0;
  bit bp_en = 0;
  bit monitor_on = 0;

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", rq, what, act, expv, $time);
    end
  endtask

  function automatic string code_req(input logic [1:0] c);
    case (c)
      2'd0: return "R1";
      2'd1: return "R2";
      2'd2: return "R5";
      default: return "R6";
    endcase
  endfunction

  // Reference model: expected beats and error pulses, compared each cycle
  always @(negedge clk) begin
    if (monitor_on) begin
      chk(cpl_valid === (exp_q.size() != 0), "R9", "cpl_valid", cpl_valid, exp_q.size() != 0);
      chk(req_ready === (exp_q.size() == 0), "R9", "req_ready", req_ready, exp_q.size() == 0);
      if (cpl_valid === 1'b1 && exp_q.size() != 0) begin
        beat_t b;
        string rq;
        b = exp_q[0];
        rq = stalled_prev ? "R8" : b.rq;
        chk(cpl_sop === b.sop, rq, "sop", cpl_sop, b.sop);
        chk(cpl_last === b.last, b.len == 0 ? "R4" : rq, "last", cpl_last, b.last);
        chk(cpl_data === b.data, rq, "data", cpl_data, b.data);
        chk(cpl_status === b.status, code_req(b.status - 2'd1), "status", cpl_status, b.status);
        chk(cpl_tag === b.tag && cpl_rid === b.rid, "R7", "tag/rid",
            {cpl_tag, cpl_rid}, {b.tag, b.rid});
        chk(cpl_len === b.len, "R7", "len", cpl_len, b.len);
      end
      chk(err_valid === err_pend, "R10", "err_valid", err_valid, err_pend);
      if (err_pend)
        chk(err_code === err_exp, code_req(err_exp), "err_code", err_code, err_exp);
      err_pend = 0;
      stalled_prev = (cpl_valid === 1'b1) && (cpl_ready === 1'b0);
      if (cpl_valid === 1'b1 && cpl_ready === 1'b1 && exp_q.size() != 0) void'(exp_q.pop_front());
      if (req_valid === 1'b1 && req_ready === 1'b1) begin
        beat_t h;
        err_pend = 1;
        h.tag = req_tag; h.rid = req_rid; h.sop = 1; h.data = '0;
        if (req_kind == 2'd0) begin
          err_exp = req_abort ? 2'd1 : 2'd0;
          h.status = req_abort ? 2'd2 : 2'd1;
          h.len = req_len; h.last = (req_len == 0);
          h.rq = req_abort ? "R2" : "R1";
          exp_q.push_back(h);
          for (int i = 0; i < int'(req_len); i++) begin
            beat_t d;
            d = h; d.sop = 0; d.data = '1; d.last = (i == int'(req_len) - 1); d.rq = "R3";
            exp_q.push_back(d);
          end
        end else if (req_kind == 2'd1) begin
          err_exp = 2'd2;
        end else begin
          err_exp = 2'd3;
          if (req_cpl_req) begin
            h.status = 2'd3; h.len = '0; h.last = 1; h.rq = "R6";
            exp_q.push_back(h);
          end
        end
      end
    end
  end

  always begin
    @(posedge clk); #1;
    cpl_ready = bp_en ? (($urandom % 3) != 0) : 1'b1;
  end

  task automatic send(input logic [1:0] k, input bit ab, input bit cr,
                      input int len, input int tag);
    req_kind = k; req_abort = ab; req_cpl_req = cr;
    req_len = LEN_W'(len); req_tag = TAG_W'(tag); req_rid = RID_W'(16'hA000 + tag);
    req_valid = 1'b1;
    do @(negedge clk); while (req_ready !== 1'b1);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (2000 * 100) @(posedge clk);
    chk(0, "WATCHDOG", "timeout", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(cpl_valid === 1'b0, "R11", "cpl_valid", cpl_valid, 0);
    chk(err_valid === 1'b0, "R11", "err_valid", err_valid, 0);
    chk(req_ready === 1'b1, "R11", "req_ready", req_ready, 1);
    monitor_on = 1;
    @(posedge clk); #1;
    send(2'd0, 0, 0, 3, 1);     // R1 read master abort
    send(2'd0, 1, 0, 2, 2);     // R2 read target abort
    send(2'd0, 0, 0, 0, 3);     // R4 zero length
    send(2'd1, 0, 0, 5, 4);     // R5 write dropped
    send(2'd1, 1, 0, 1, 5);     // R5 write with target flag
    send(2'd1, 0, 0, 2, 6);     // R5 back-to-back write
    send(2'd2, 0, 0, 0, 7);     // R6 no completion
    send(2'd3, 0, 1, 9, 8);     // R6 completion, length forced 0
    send(2'd0, 1, 0, 15, 9);    // R3 max length
    bp_en = 1;
    send(2'd0, 0, 0, 4, 10);    // R8 stalls
    send(2'd2, 1, 1, 0, 11);
    for (int n = 0; n < 400; n++)
      send(2'($urandom % 4), 1'($urandom % 2), 1'($urandom % 2),
           int'($urandom % 16), n + 12);
    repeat (40) @(posedge clk);
    chk(exp_q.size() == 0, "R9", "drained", exp_q.size(), 0);
    finish_run();
  end

endmodule